// File: doc/BRIEF.md
# SM2 Prime-Field Modular Multiplier

This block computes the product of two 256-bit field elements modulo the SM2 prime
p = 2^256 - 2^224 - 2^96 + 2^64 - 1. A caller places both operands on the inputs
and raises `start_i` for one cycle. The block then holds `busy_o` high while it
works. When it finishes it drops `busy_o`, raises `done_o` for exactly one cycle
and presents the reduced result on `result_o`.

The full 512-bit product is built by one limb multiply-accumulate unit. It handles
one pair of limbs per cycle, taking them in column order (constant i+j), and
accumulates each partial product at its column offset. The double-width product
is then reduced by a folding stage that relies on the shape of the prime. Since
2^256 is congruent to 2^224 + 2^96 - 2^64 + 1, the upper half is added back into
the lower half with three positive terms and one negative term, all at
word-aligned offsets. The fold repeats until the upper half is zero. Conditional
subtractions of p then bring the value below p.

Top module: `sm2_modmul`

## Requirements
- R1: For operands a, b < p, the value on `result_o` while `done_o` is high equals (a*b) mod p.
- R2: Whenever `done_o` is high, `result_o` is strictly less than p.
- R3: `done_o` is high for exactly one cycle per accepted operation.
- R4: `busy_o` is high from the cycle after an accepted start (start_i high while busy_o low) up to the completion. It is low in the cycle `done_o` is high.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running operation finishes with its original operands, and no extra completion follows.
- R6: The multiply phase lasts exactly (256/LIMB_W)^2 cycles, which is 16 at the default limb width, with one limb product per cycle.
- R7: After reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R8: Boundary operands give exact results: 0*x = 0, 1*x = x, (p-1)*(p-1) = 1 and (p-1)*2 = p-2.
- R9: `done_o` rises no earlier than 18 and no later than 40 cycles after the accepted start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| a_i | input | 256 | Multiplicand, below p |
| b_i | input | 256 | Multiplier, below p |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 256 | (a*b) mod p, valid with done_o |

## Verification
The bench builds the block with the default 64-bit limb. This gives a 4x4 limb schedule of 16 products over seven columns. Under that schedule, carries between columns and the worst-case fold count can be reached by operands near p. Operands such as p-1, together with pseudo-random values reduced below p, drive the fold loop through its longest chains. They also drive the final subtraction through both of its outcomes. Every result is compared against a bit-serial shift-and-add modular model.

// File: rtl/sm2_modmul_pkg.sv
package sm2_modmul_pkg;
  localparam int unsigned OP_W  = 256;
  localparam int unsigned DBL_W = 2 * OP_W;
  localparam logic [OP_W-1:0] SM2_P =
    256'hFFFFFFFE_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_00000000_FFFFFFFF_FFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MUL, ST_LOAD, ST_FOLD, ST_FINAL
  } state_e;

  typedef enum logic [1:0] {
    RED_HOLD, RED_LOAD, RED_FOLD, RED_SUB
  } red_op_e;

  // limb index pair of the idx-th product in column order, packed {i, j}
  function automatic logic [15:0] col_pair(int idx, int n);
    int k;
    logic [15:0] r;
    k = 0;
    r = '0;
    for (int c = 0; c < 2 * n - 1; c++) begin
      for (int i = 0; i < n; i++) begin
        if ((c - i) >= 0 && (c - i) < n) begin
          if (k == idx) r = {8'(i), 8'(c - i)};
          k++;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sm2_limb_sched.sv
module sm2_limb_sched #(
  parameter int unsigned N_LIMBS = 4,
  localparam int unsigned N_PROD = N_LIMBS * N_LIMBS,
  localparam int unsigned IDX_W  = $clog2(N_LIMBS),
  localparam int unsigned CNT_W  = $clog2(N_PROD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [IDX_W-1:0] i_o,
  output logic [IDX_W-1:0] j_o,
  output logic [IDX_W:0]   col_o,
  output logic             last_o
);
  import sm2_modmul_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0] tab_i [N_PROD];
  logic [7:0] tab_j [N_PROD];

  for (genvar g = 0; g < N_PROD; g++) begin : g_tab
    localparam logic [15:0] PAIR = col_pair(g, N_LIMBS);
    assign tab_i[g] = PAIR[15:8];
    assign tab_j[g] = PAIR[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign i_o    = tab_i[cnt_q][IDX_W-1:0];
  assign j_o    = tab_j[cnt_q][IDX_W-1:0];
  assign col_o  = {1'b0, i_o} + {1'b0, j_o};
  assign last_o = (cnt_q == CNT_W'(N_PROD - 1));
endmodule

// File: rtl/sm2_mac.sv
module sm2_mac #(
  parameter int unsigned LIMB_W = 64,
  parameter int unsigned ACC_W  = 512,
  parameter int unsigned COL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [LIMB_W-1:0] a_i,
  input  logic [LIMB_W-1:0] b_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [2*LIMB_W-1:0] prod;
  logic [ACC_W-1:0]    term;
  logic [ACC_W-1:0]    acc_q;

  assign prod = a_i * b_i;
  assign term = ACC_W'(prod) << (col_i * LIMB_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + term;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sm2_fold_red.sv
module sm2_fold_red
  import sm2_modmul_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  red_op_e          op_i,
  input  logic [DBL_W-1:0] load_i,
  output logic [OP_W-1:0]  val_o,
  output logic             hi_zero_o,
  output logic             ge_p_o
);
  logic [DBL_W-1:0] r_q;
  logic [DBL_W-1:0] hx, lx, folded, subbed;

  assign hx = {{OP_W{1'b0}}, r_q[DBL_W-1:OP_W]};
  assign lx = {{OP_W{1'b0}}, r_q[OP_W-1:0]};

  // 2^256 == 2^224 + 2^96 - 2^64 + 1 (mod p); the sum never goes negative
  assign folded = lx + (hx << 224) + (hx << 96) + hx - (hx << 64);
  assign subbed = r_q - {{OP_W{1'b0}}, SM2_P};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '0;
    else begin
      unique case (op_i)
        RED_LOAD: r_q <= load_i;
        RED_FOLD: r_q <= folded;
        RED_SUB:  r_q <= subbed;
        default:  r_q <= r_q;
      endcase
    end
  end

  assign val_o     = r_q[OP_W-1:0];
  assign hi_zero_o = (r_q[DBL_W-1:OP_W] == '0);
  assign ge_p_o    = (r_q[OP_W-1:0] >= SM2_P);
endmodule

// File: rtl/sm2_modmul.sv
module sm2_modmul
  import sm2_modmul_pkg::*;
#(
  parameter int unsigned LIMB_W = 64,
  localparam int unsigned N_LIMBS = OP_W / LIMB_W,
  localparam int unsigned N_PROD  = N_LIMBS * N_LIMBS,
  localparam int unsigned IDX_W   = $clog2(N_LIMBS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [OP_W-1:0] result_o
);
  state_e state_q;
  red_op_e red_op;
  logic [OP_W-1:0] a_q, b_q;
  logic [IDX_W-1:0] li, lj;
  logic [IDX_W:0] col;
  logic last, accept, mul_active;
  logic [DBL_W-1:0] acc;
  logic [OP_W-1:0] red_val;
  logic hi_zero, ge_p;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign mul_active = (state_q == ST_MUL);
  assign busy_o     = (state_q != ST_IDLE);

  sm2_limb_sched #(.N_LIMBS(N_LIMBS)) u_sched (
    .clk_i, .rst_ni,
    .clr_i (accept),
    .en_i  (mul_active),
    .i_o   (li),
    .j_o   (lj),
    .col_o (col),
    .last_o(last)
  );

  sm2_mac #(.LIMB_W(LIMB_W), .ACC_W(DBL_W), .COL_W(IDX_W + 1)) u_mac (
    .clk_i, .rst_ni,
    .clr_i (accept),
    .en_i  (mul_active),
    .a_i   (a_q[li*LIMB_W +: LIMB_W]),
    .b_i   (b_q[lj*LIMB_W +: LIMB_W]),
    .col_i (col),
    .acc_o (acc)
  );

  always_comb begin
    red_op = RED_HOLD;
    unique case (state_q)
      ST_LOAD:  red_op = RED_LOAD;
      ST_FOLD:  if (!hi_zero) red_op = RED_FOLD;
      ST_FINAL: if (ge_p) red_op = RED_SUB;
      default:  red_op = RED_HOLD;
    endcase
  end

  sm2_fold_red u_red (
    .clk_i, .rst_ni,
    .op_i     (red_op),
    .load_i   (acc),
    .val_o    (red_val),
    .hi_zero_o(hi_zero),
    .ge_p_o   (ge_p)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          a_q     <= a_i;
          b_q     <= b_i;
          state_q <= ST_MUL;
        end
        ST_MUL:  if (last) state_q <= ST_LOAD;
        ST_LOAD: state_q <= ST_FOLD;
        ST_FOLD: if (hi_zero) state_q <= ST_FINAL;
        ST_FINAL: if (!ge_p) begin
          result_o <= red_val;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sm2_modmul_chk.sv
module sm2_modmul_chk
  import sm2_modmul_pkg::*;
#(
  parameter int unsigned N_PROD  = 16,
  parameter int unsigned MAX_LAT = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mul_active,
  input logic [OP_W-1:0] result_o
);
  logic [7:0] mul_run_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mul_run_q <= '0;
      lat_q     <= '0;
    end else begin
      mul_run_q <= mul_active ? mul_run_q + 1'b1 : '0;
      lat_q     <= busy_o ? lat_q + 1'b1 : '0;
    end
  end

  // R2
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o < SM2_P));
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6
  mul_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mul_active && mul_run_q != 0) |-> (mul_run_q == 8'(N_PROD)));
  // R9
  lat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (lat_q < 8'(MAX_LAT)));
endmodule

bind sm2_modmul sm2_modmul_chk #(.N_PROD(N_PROD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mul_active(mul_active),
  .result_o  (result_o)
);

// File: tb/sm2_modmul_tb.sv
`timescale 1ns/1ps
module sm2_modmul_tb;
  localparam logic [255:0] P =
    256'hFFFFFFFE_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_00000000_FFFFFFFF_FFFFFFFF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [255:0] a_i = '0, b_i = '0;
  logic busy_o, done_o;
  logic [255:0] result_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  sm2_modmul u_dut (.*);

  function automatic logic [255:0] ref_mul(logic [255:0] a, logic [255:0] b);
    logic [256:0] r = '0;
    for (int k = 255; k >= 0; k--) begin
      r = r << 1;
      if (r >= {1'b0, P}) r = r - {1'b0, P};
      if (a[k]) begin
        r = r + {1'b0, b};
        if (r >= {1'b0, P}) r = r - {1'b0, P};
      end
    end
    return r[255:0];
  endfunction

  function automatic logic [255:0] rnd_elem();
    logic [255:0] x;
    for (int w = 0; w < 8; w++) x[w*32 +: 32] = $urandom;
    if (x >= P) x = x - P;
    return x;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one op; returns result and cycles from start edge to done
  task automatic run_op(logic [255:0] a, logic [255:0] b,
                        output logic [255:0] res, output int lat);
    @(negedge clk_i);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    res = result_o;
  endtask

  task automatic t_reset();
    check("R7 busy", {255'b0, busy_o}, '0);
    check("R7 done", {255'b0, done_o}, '0);
    check("R7 result", result_o, '0);
  endtask

  task automatic t_op(string req, logic [255:0] a, logic [255:0] b);
    logic [255:0] res;
    int lat;
    run_op(a, b, res, lat);
    check({req, " R1 value"}, res, ref_mul(a, b));
    check("R2 range", {255'b0, res < P}, 256'd1);
    // R9 window: 16 products, load, final compare at minimum
    check("R9 latency", {255'b0, (lat >= 18 && lat <= 40)}, 256'd1);
    @(negedge clk_i);
    check("R3 single pulse", {255'b0, done_o}, '0);
  endtask

  task automatic t_corners();
    logic [255:0] x = rnd_elem();
    t_op("R8 zero", '0, x);
    t_op("R8 one", 256'd1, x);
    t_op("R8 pm1sq", P - 1, P - 1);
    t_op("R8 pm1x2", P - 1, 256'd2);
    t_op("R8 high", P - 2, P - 3);
  endtask

  task automatic t_random(int n);
    for (int k = 0; k < n; k++) t_op("R1 random", rnd_elem(), rnd_elem());
  endtask

  task automatic t_busy_ignore();
    logic [255:0] a = rnd_elem(), b = rnd_elem();
    int dones = 0;
    logic [255:0] res = '0;
    @(negedge clk_i);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R4 busy after start", {255'b0, busy_o}, 256'd1);
    repeat (4) @(negedge clk_i);
    a_i = rnd_elem(); b_i = rnd_elem(); start_i = 1'b1; // R5 stray start
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 120; c++) begin
      if (done_o) begin
        dones++;
        res = result_o;
        check("R4 idle at done", {255'b0, busy_o}, '0);
      end
      @(negedge clk_i);
    end
    check("R5 result", res, ref_mul(a, b));
    check("R5 one completion", 256'(dones), 256'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_corners();
    t_random(12);
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule